// File: doc/BRIEF.md
# Power-Rail Startup Sequencer

This block brings a processor's supply rails up in a fixed order after a pushbutton press. While the system is off, it watches only an active-low pushbutton. It confirms the press with a debounce delay and then signals a keypress on an active-low output. After that it switches on the rails in groups: an external regulator first, then one linear regulator and one switching converter, then two more switching converters, and finally the last linear regulator once the processor asks for it. At the end it releases the processor's active-low reset, a fixed time after the main converter reports that its output is good.

Every delay is counted in pulses of a one-cycle millisecond strobe. The debounce, first-step and reset-release lengths are parameters, so a test can use short values. Two 3-bit select codes choose the ordering, and this block supports one pair of them. The reset values of the codes are that pair, so a first power-up follows the right order. If the codes hold any other pair when the button is pressed, the block stays off and sets a sticky error flag.

Top module: `rail_seq_top`

## Requirements
- R1: After reset every enable output is low, `key_n` is high, `cpu_rst_n` is low and `cfg_err` is low.
- R2: In the off state a falling edge on `btn_n` starts a debounce when `conv_code` is 3'b100 and `reg_code` is 3'b111. During the debounce every output keeps its off value.
- R3: `key_n` goes low and `ext_en` goes high together, on the clock edge that samples the DEB_MS-th strobe seen with `btn_n` still low. If `btn_n` returns high before that, the block goes back to off and asserts no output.
- R4: `ldo2_en` and `dc3_en` rise together on the edge that samples the EXT_MS-th strobe after `ext_en` rose.
- R5: `dc1_en` and `dc2_en` rise together on the first clock edge that samples `pg_ldo2` high after `ldo2_en` is on.
- R6: `ldo1_en` rises on the first clock edge that samples `cpu_en_req` high after `dc1_en` is on.
- R7: `cpu_rst_n` goes high on the edge that samples the RST_MS-th strobe counted while `dc1_en` and `pg_dc1` are both high.
- R8: When `pg_dc1` falls, `cpu_rst_n` goes low in the same cycle. Release then needs a fresh RST_MS strobes of good power.
- R9: A press while the codes are not the supported pair leaves every output off and sets `cfg_err`. `cfg_err` stays set until reset, including across later presses that succeed.
- R10: The enables always nest in sequence order: `ldo1_en` implies `dc1_en`, `dc1_en` implies `ldo2_en`, and `ldo2_en` implies `ext_en`. `dc2_en` always equals `dc1_en`, and `dc3_en` always equals `ldo2_en`.
- R11: Once a rail enable is high it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| btn_n | input | 1 | Pushbutton, active low |
| pg_ldo2 | input | 1 | Power-good from linear regulator 2 |
| pg_dc1 | input | 1 | Power-good from switching converter 1 |
| cpu_en_req | input | 1 | Enable request from the processor |
| conv_code | input | 3 | Converter ordering select |
| reg_code | input | 3 | Linear-regulator ordering select |
| key_n | output | 1 | Keypress indication, active low |
| ext_en | output | 1 | External regulator enable |
| dc1_en | output | 1 | Switching converter 1 enable |
| dc2_en | output | 1 | Switching converter 2 enable |
| dc3_en | output | 1 | Switching converter 3 enable |
| ldo1_en | output | 1 | Linear regulator 1 enable |
| ldo2_en | output | 1 | Linear regulator 2 enable |
| cpu_rst_n | output | 1 | Processor reset, released high |
| cfg_err | output | 1 | Sticky unsupported-code flag |

## Verification
The assertions are checked on every cycle. They cover the nesting of the enables, the rule that no rail drops once it is on, and the rule that each rail group rises only on the cause allowed for it: a strobe, a power-good flag or the processor's request. They also cover that the error flag stays set and that the delay counters stay below their limits. Only the bench's scenarios can show the exact strobe counts. Those are the 50 ms debounce and its early-release abort, the 1 ms first step, and the 20 ms reset release, both the first time and again after power-good is lost. The scenarios also show which code pairs are accepted.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_DEB, ST_EXT, ST_RAMPA, ST_RAMPB, ST_ON
  } seq_state_t;

  localparam logic [2:0] CONV_OK = 3'b100;
  localparam logic [2:0] REG_OK  = 3'b111;

  function automatic logic codes_supported(input logic [2:0] conv, input logic [2:0] rg);
    return (conv == CONV_OK) && (rg == REG_OK);
  endfunction

  function automatic logic count_expires(input int unsigned cnt, input int unsigned limit,
                                         input logic tick);
    return tick && (cnt + 1 >= limit);
  endfunction
endpackage

// File: rtl/rail_seq_timer.sv
module rail_seq_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = rail_seq_pkg::count_expires(int'(cnt), int'(limit), tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || done)  cnt <= '0;
    else if (tick)         cnt <= cnt + 1'b1;
  end

  // R3 / R7: a counter never reaches its limit without expiring
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> (cnt < limit));
endmodule

// File: rtl/rail_seq_rstgen.sv
module rail_seq_rstgen #(
  parameter int CW     = 6,
  parameter int RST_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic dc1_en,
  input  logic pg_dc1,
  output logic cpu_rst_n
);
  logic rel_q;
  logic run_ok;
  logic rel_done;
  logic rel_clr;

  assign run_ok  = dc1_en && pg_dc1;
  assign rel_clr = !run_ok || rel_q;

  rail_seq_timer #(.CW(CW)) u_rel_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(rel_clr),
    .limit(CW'(RST_MS)), .done(rel_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rel_q <= 1'b0;
    else if (!run_ok)            rel_q <= 1'b0;
    else if (!rel_q && rel_done) rel_q <= 1'b1;
  end

  assign cpu_rst_n = rel_q && pg_dc1;

  // R7: release only follows a strobe sampled with good power
  a_r7_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_q) |-> $past(tick) && $past(pg_dc1) && $past(dc1_en));
  // R8: released reset never coexists with lost power-good
  a_r8_drop_now: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_q && !pg_dc1) |=> !rel_q);
endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       btn_n,
  input  logic       pg_ldo2,
  input  logic       cpu_en_req,
  input  logic [2:0] conv_code,
  input  logic [2:0] reg_code,
  input  logic       seq_done,
  output logic       seq_clr,
  output logic       ext_phase,
  output logic       key_n,
  output logic       ext_en,
  output logic       grp_a_en,
  output logic       grp_b_en,
  output logic       ldo1_en,
  output logic       cfg_err
);
  import rail_seq_pkg::*;

  seq_state_t state, nxt;
  logic btn_q;
  logic btn_fall;
  logic bad_press;

  assign btn_fall  = btn_q && !btn_n;
  assign bad_press = (state == ST_OFF) && btn_fall && !codes_supported(conv_code, reg_code);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:   if (btn_fall && codes_supported(conv_code, reg_code)) nxt = ST_DEB;
      ST_DEB:   if (btn_n) nxt = ST_OFF; else if (seq_done) nxt = ST_EXT;
      ST_EXT:   if (seq_done)   nxt = ST_RAMPA;
      ST_RAMPA: if (pg_ldo2)    nxt = ST_RAMPB;
      ST_RAMPB: if (cpu_en_req) nxt = ST_ON;
      ST_ON:    nxt = ST_ON;
      default:  nxt = ST_OFF;
    endcase
  end

  assign seq_clr   = (state != nxt) || !((state == ST_DEB) || (state == ST_EXT));
  assign ext_phase = (state == ST_EXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      btn_q   <= 1'b1;
      cfg_err <= 1'b0;
    end else begin
      state <= nxt;
      btn_q <= btn_n;
      if (bad_press) cfg_err <= 1'b1;
    end
  end

  assign key_n    = (state == ST_OFF) || (state == ST_DEB);
  assign ext_en   = !key_n;
  assign grp_a_en = (state == ST_RAMPA) || (state == ST_RAMPB) || (state == ST_ON);
  assign grp_b_en = (state == ST_RAMPB) || (state == ST_ON);
  assign ldo1_en  = (state == ST_ON);

  // R3: the external regulator comes up only while the button is held
  a_r3_ext_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_en) |-> $past(!btn_n) && $past(ms_tick));
  // R4: the first rail group rises on a strobe
  a_r4_grp_a_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_a_en) |-> $past(ms_tick));
  // R5: the second group rises on the regulator's power-good
  a_r5_grp_b_pg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grp_b_en) |-> $past(pg_ldo2));
  // R6: the last rail rises on the processor's request
  a_r6_ldo1_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldo1_en) |-> $past(cpu_en_req));
  // R9: the error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R11: no rail drops once enabled
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en |=> ext_en) and (grp_a_en |=> grp_a_en) and (grp_b_en |=> grp_b_en));
endmodule

// File: rtl/rail_seq_top.sv
module rail_seq_top #(
  parameter int DEB_MS = 50,
  parameter int EXT_MS = 1,
  parameter int RST_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       btn_n,
  input  logic       pg_ldo2,
  input  logic       pg_dc1,
  input  logic       cpu_en_req,
  input  logic [2:0] conv_code,
  input  logic [2:0] reg_code,
  output logic       key_n,
  output logic       ext_en,
  output logic       dc1_en,
  output logic       dc2_en,
  output logic       dc3_en,
  output logic       ldo1_en,
  output logic       ldo2_en,
  output logic       cpu_rst_n,
  output logic       cfg_err
);
  localparam int MAXD = (DEB_MS > EXT_MS) ? ((DEB_MS > RST_MS) ? DEB_MS : RST_MS)
                                          : ((EXT_MS > RST_MS) ? EXT_MS : RST_MS);
  localparam int CW = $clog2(MAXD + 1);

  logic seq_done, seq_clr, ext_phase, grp_a_en, grp_b_en;
  logic [CW-1:0] seq_limit;

  assign seq_limit = ext_phase ? CW'(EXT_MS) : CW'(DEB_MS);

  rail_seq_timer #(.CW(CW)) u_seq_tmr (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .clr(seq_clr),
    .limit(seq_limit), .done(seq_done)
  );

  rail_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_n(btn_n),
    .pg_ldo2(pg_ldo2), .cpu_en_req(cpu_en_req),
    .conv_code(conv_code), .reg_code(reg_code),
    .seq_done(seq_done), .seq_clr(seq_clr), .ext_phase(ext_phase),
    .key_n(key_n), .ext_en(ext_en), .grp_a_en(grp_a_en), .grp_b_en(grp_b_en),
    .ldo1_en(ldo1_en), .cfg_err(cfg_err)
  );

  assign ldo2_en = grp_a_en;
  assign dc3_en  = grp_a_en;
  assign dc1_en  = grp_b_en;
  assign dc2_en  = grp_b_en;

  rail_seq_rstgen #(.CW(CW), .RST_MS(RST_MS)) u_rst (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .dc1_en(dc1_en),
    .pg_dc1(pg_dc1), .cpu_rst_n(cpu_rst_n)
  );

  // R10: enables nest in sequence order at the ports
  a_r10_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (ldo1_en |-> dc1_en && dc2_en) and (dc1_en |-> ldo2_en && dc3_en) and (ldo2_en |-> ext_en));
  // R9: an error press brings up nothing
  a_r9_err_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> !ext_en);
endmodule

// File: tb/sim_rail_seq_top.sv
module sim_rail_seq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, btn_n = 1'b1, pg_ldo2 = 1'b0, pg_dc1 = 1'b0, cpu_en_req = 1'b0;
  logic [2:0] conv_code = 3'b100, reg_code = 3'b111;
  logic key_n, ext_en, dc1_en, dc2_en, dc3_en, ldo1_en, ldo2_en, cpu_rst_n, cfg_err;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rail_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_n(btn_n), .pg_ldo2(pg_ldo2),
    .pg_dc1(pg_dc1), .cpu_en_req(cpu_en_req), .conv_code(conv_code), .reg_code(reg_code),
    .key_n(key_n), .ext_en(ext_en), .dc1_en(dc1_en), .dc2_en(dc2_en), .dc3_en(dc3_en),
    .ldo1_en(ldo1_en), .ldo2_en(ldo2_en), .cpu_rst_n(cpu_rst_n), .cfg_err(cfg_err)
  );

  // {conv, reg, accepted}
  localparam logic [6:0] CODES [6] = '{
    {3'b100, 3'b111, 1'b1}, {3'b000, 3'b111, 1'b0}, {3'b100, 3'b000, 1'b0},
    {3'b111, 3'b111, 1'b0}, {3'b100, 3'b110, 1'b0}, {3'b101, 3'b111, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1; @(negedge clk);
      ms_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; btn_n = 1'b1; ms_tick = 1'b0; pg_ldo2 = 1'b0; pg_dc1 = 1'b0;
    cpu_en_req = 1'b0; conv_code = 3'b100; reg_code = 3'b111;
    step(3); rst_n = 1'b1; step(1);
  endtask

  function automatic logic [8:0] outs();
    return {key_n, ext_en, dc1_en, dc2_en, dc3_en, ldo1_en, ldo2_en, cpu_rst_n, cfg_err};
  endfunction

  initial begin
    do_reset();
    chk("R1 reset outputs", 32'(outs()), 32'b1_0000_0000);

    // table of code pairs
    for (int k = 0; k < 6; k++) begin
      do_reset();
      conv_code = CODES[k][6:4]; reg_code = CODES[k][3:1];
      btn_n = 1'b0; step(1);
      chk("R9 err after press", 32'(cfg_err), 32'(!CODES[k][0]));
      ticks(50);
      chk("R2/R9 key after hold", 32'(key_n), 32'(!CODES[k][0]));
      chk("R9 ext after hold", 32'(ext_en), 32'(CODES[k][0]));
    end

    // R9 sticky across a good press
    do_reset();
    conv_code = 3'b010; btn_n = 1'b0; step(1); ticks(60);
    chk("R9 bad press stays off", 32'(outs()), 32'b1_0000_0001);
    btn_n = 1'b1; conv_code = 3'b100; step(2);
    btn_n = 1'b0; step(1); ticks(50);
    chk("R9 good press proceeds", 32'(ext_en), 32'd1);
    chk("R9 flag stays set", 32'(cfg_err), 32'd1);

    // R3 early release aborts
    do_reset();
    btn_n = 1'b0; step(1); ticks(30);
    btn_n = 1'b1; step(1); ticks(40);
    chk("R3 abort no output", 32'(outs()), 32'b1_0000_0000);

    // main sequence
    do_reset();
    btn_n = 1'b0; step(1);
    chk("R2 debounce quiet", 32'(outs()), 32'b1_0000_0000);
    ticks(49);
    chk("R3 before 50th tick", 32'({key_n, ext_en}), 32'b10);
    ticks(1);
    chk("R3 at 50th tick", 32'({key_n, ext_en}), 32'b01);
    chk("R4 grp a not yet", 32'({ldo2_en, dc3_en}), 32'b00);
    ticks(1);
    chk("R4 ldo2+dc3 on", 32'({ldo2_en, dc3_en, dc1_en}), 32'b110);
    step(3);
    chk("R5 wait for pg", 32'({dc1_en, dc2_en}), 32'b00);
    pg_ldo2 = 1'b1; step(1);
    chk("R5 dc1+dc2 on", 32'({dc1_en, dc2_en, ldo1_en}), 32'b110);
    step(3);
    chk("R6 wait for req", 32'(ldo1_en), 32'd0);
    cpu_en_req = 1'b1; step(1);
    chk("R6 ldo1 on", 32'(ldo1_en), 32'd1);
    chk("R10 full set", 32'(outs()), 32'b0_1111_1100);
    pg_dc1 = 1'b1; step(1); ticks(19);
    chk("R7 before 20th tick", 32'(cpu_rst_n), 32'd0);
    ticks(1);
    chk("R7 released", 32'(cpu_rst_n), 32'd1);
    @(posedge clk); #3 pg_dc1 = 1'b0; #1;
    chk("R8 same-cycle drop", 32'(cpu_rst_n), 32'd0);
    step(2); pg_dc1 = 1'b1; step(1); ticks(19);
    chk("R8 fresh count needed", 32'(cpu_rst_n), 32'd0);
    ticks(1);
    chk("R8 re-release", 32'(cpu_rst_n), 32'd1);
    pg_ldo2 = 1'b0; cpu_en_req = 1'b0; btn_n = 1'b1; step(5);
    chk("R11 rails held", 32'(outs()), 32'b0_1111_1110);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule